// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the register face of a shared-memory link between compute nodes. Software on the local node uses a 32-bit register bus to set an interrupt mask, to read and clear an interrupt status word, to learn its own node number, and to ring a doorbell toward a peer node. A doorbell write carries the target peer in its upper half-word and the vector number in its low byte. The block checks both against the peers currently known and the number of vectors each peer has connected. A valid request leaves the block as a single-cycle notify pulse that carries the peer and vector.

Notifications that arrive for the local node come in on an event input and load the status word. In pin-interrupt mode a level interrupt output follows the masked status. When message-signalled delivery is selected on a static input, that pin stays low. A sideband port, driven by the link manager rather than software, loads the known peer count and the per-peer vector counts.

Top module: `doorbell_regs`

## Requirements
- R1: After reset the mask and status words read as zero, the interrupt output is low and no notify pulse is present.
- R2: A write at byte offset 0x00 loads the mask word, and a read at 0x00 returns it. Read data appears on `busRdata` in the cycle after the read request, and is zero in any cycle that follows no read.
- R3: A write at offset 0x04 loads the status word. A read at offset 0x04 returns the current status and leaves the status at zero, unless the same cycle also writes it or carries a local event.
- R4: With `msiMode` low, `irqOut` is high exactly when status AND mask is nonzero. It reflects a mask or status change in the cycle after the write.
- R5: With `msiMode` high, `irqOut` stays low whatever status and mask hold.
- R6: A read at offset 0x08 returns `ownId` zero-extended to 32 bits.
- R7: A write at offset 0x0C whose peer field (bits 31:16) is below the peer count, and whose vector field (bits 7:0) is below that peer's vector count, gives `notifyValid` high for one cycle in the cycle after the write. `notifyPeer` and `notifyVector` carry the two fields.
- R8: A doorbell write whose peer field is equal to or above the peer count gives no notify pulse.
- R9: A doorbell write whose vector field is equal to or above the target peer's vector count gives no notify pulse. A peer with a count of zero accepts no vector.
- R10: Writes ignore address bits 1:0, so offsets 0x0D to 0x0F act as the doorbell and 0x01 to 0x03 act as the mask. Reads decode the full address.
- R11: Reads at any offset other than exactly 0x00, 0x04 or 0x08 return zero. This includes the doorbell offset. Writes to offsets outside the three writable words change no register.
- R12: A local event loads the status with the value 1, and it wins over a status write in the same cycle. A status read in the same cycle as an event returns the old status and leaves the status at 1.
- R13: `cntWe` loads the peer count from `cntVal`, limited to 2^NODE_BITS. `tblWe` loads `tblCount` as the vector count of peer `tblPeer`. A doorbell in the same cycle as a table update is judged on the values from before the update. All counts reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msiMode | input | 1 | Static: 1 selects message-signalled delivery and holds the pin low |
| ownId | input | 16 | Node number of this node |
| busAddr | input | 8 | Byte address inside the 256-byte register window |
| busWrEn | input | 1 | Write request, 32-bit |
| busRdEn | input | 1 | Read request, 32-bit |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRdEn |
| localEvent | input | 1 | Notification arrived for this node |
| tblWe | input | 1 | Load one peer's vector count |
| tblPeer | input | NODE_BITS | Peer whose vector count is loaded |
| tblCount | input | 8 | Number of vectors connected for that peer |
| cntWe | input | 1 | Load the peer count |
| cntVal | input | NODE_BITS+1 | New peer count |
| irqOut | output | 1 | Level interrupt, pin mode |
| notifyValid | output | 1 | One-cycle doorbell notify strobe |
| notifyPeer | output | 16 | Destination peer of the notify |
| notifyVector | output | 8 | Vector of the notify |

## Verification
The embedded properties watch, on every cycle, that the pin stays quiet in message-signalled mode and that a clean status read leaves zero. They also check that an event leaves the status at one, that a notify pulse always follows a doorbell strobe and names a peer below the count from before it, and that no two write strobes fire together. Only the bench scenarios show the values themselves. These are the read data per offset, the masked interrupt level, the field extraction and the two range checks on doorbell writes, the low-bit aliasing of write addresses, the clamping of the peer count, and the ordering between a status read, a status write and a local event in one cycle.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  localparam logic [7:0] OFF_MASK = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_POS  = 8'h08;
  localparam logic [7:0] OFF_BELL = 8'h0C;
  localparam int VEC_W = 8;
  localparam int ID_W  = 16;

  typedef struct packed {
    logic wrMask;
    logic wrStatus;
    logic wrBell;
    logic rdMask;
    logic rdStatus;
    logic rdPos;
  } strobe_t;
endpackage

// File: rtl/dbl_ctrl.sv
module dbl_ctrl
  import dbl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busAddr,
  input  logic       busWrEn,
  input  logic       busRdEn,
  output strobe_t    strobes
);
  logic [7:0] wordAddr;
  assign wordAddr = {busAddr[7:2], 2'b00};

  always_comb begin
    strobes = '0;
    if (busWrEn) begin
      // writes drop the two low address bits (R10)
      case (wordAddr)
        OFF_MASK: strobes.wrMask   = 1'b1;
        OFF_STAT: strobes.wrStatus = 1'b1;
        OFF_BELL: strobes.wrBell   = 1'b1;
        default:  ;
      endcase
    end
    if (busRdEn) begin
      // reads decode the full byte address (R11)
      case (busAddr)
        OFF_MASK: strobes.rdMask   = 1'b1;
        OFF_STAT: strobes.rdStatus = 1'b1;
        OFF_POS:  strobes.rdPos    = 1'b1;
        default:  ;
      endcase
    end
  end

  p_one_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrMask, strobes.wrStatus, strobes.wrBell}));

  p_read_aligned_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdMask || strobes.rdStatus || strobes.rdPos) |-> (busAddr[1:0] == 2'b00));
endmodule

// File: rtl/dbl_dp.sv
module dbl_dp
  import dbl_pkg::*;
#(
  parameter int NODE_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [31:0]          busWdata,
  input  logic                 msiMode,
  input  logic [ID_W-1:0]      ownId,
  input  logic                 localEvent,
  input  logic                 tblWe,
  input  logic [NODE_BITS-1:0] tblPeer,
  input  logic [VEC_W-1:0]     tblCount,
  input  logic                 cntWe,
  input  logic [NODE_BITS:0]   cntVal,
  output logic [31:0]          busRdata,
  output logic                 irqOut,
  output logic                 notifyValid,
  output logic [ID_W-1:0]      notifyPeer,
  output logic [VEC_W-1:0]     notifyVector
);
  localparam int PEERS = 1 << NODE_BITS;
  localparam int CNT_W = NODE_BITS + 1;
  localparam logic [CNT_W-1:0] PEER_MAX = CNT_W'(PEERS);

  logic [31:0]      maskQ, statusQ;
  logic [CNT_W-1:0] peerCntQ;
  logic [VEC_W-1:0] vecCnt [PEERS];

  // per-peer vector count table
  for (genvar g = 0; g < PEERS; g++) begin : gPeer
    logic [VEC_W-1:0] entQ;
    always_ff @(posedge clk) begin
      if (!rstN)                                          entQ <= '0;
      else if (tblWe && tblPeer == NODE_BITS'(g))         entQ <= tblCount;
    end
    assign vecCnt[g] = entQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      peerCntQ <= '0;
    else if (cntWe) peerCntQ <= (cntVal > PEER_MAX) ? PEER_MAX : cntVal;
  end

  // doorbell decode
  logic [ID_W-1:0]  bellPeer;
  logic [VEC_W-1:0] bellVec;
  logic             peerOk, vecOk;
  assign bellPeer = busWdata[31:16];
  assign bellVec  = busWdata[7:0];
  assign peerOk   = 32'(bellPeer) < 32'(peerCntQ);
  assign vecOk    = bellVec < vecCnt[bellPeer[NODE_BITS-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      notifyValid  <= 1'b0;
      notifyPeer   <= '0;
      notifyVector <= '0;
    end else begin
      notifyValid <= strobes.wrBell && peerOk && vecOk;
      if (strobes.wrBell && peerOk && vecOk) begin
        notifyPeer   <= bellPeer;
        notifyVector <= bellVec;
      end
    end
  end

  // mask and status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      if (strobes.wrMask) maskQ <= busWdata;
      if (localEvent)            statusQ <= 32'd1;
      else if (strobes.wrStatus) statusQ <= busWdata;
      else if (strobes.rdStatus) statusQ <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 busRdata <= '0;
    else if (strobes.rdMask)   busRdata <= maskQ;
    else if (strobes.rdStatus) busRdata <= statusQ;
    else if (strobes.rdPos)    busRdata <= 32'(ownId);
    else                       busRdata <= '0;
  end

  assign irqOut = !msiMode && ((maskQ & statusQ) != '0);

  p_msi_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    msiMode |-> !irqOut);

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStatus && !localEvent && !strobes.wrStatus) |=> (statusQ == '0));

  p_event_sets_r12: assert property (@(posedge clk) disable iff (!rstN)
    localEvent |=> (statusQ == 32'd1));

  p_notify_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> $past(strobes.wrBell));

  p_notify_peer_r8: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> (32'(notifyPeer) < 32'($past(peerCntQ))));

  p_peer_cap_r13: assert property (@(posedge clk) disable iff (!rstN)
    peerCntQ <= PEER_MAX);
endmodule

// File: rtl/doorbell_regs.sv
module doorbell_regs
  import dbl_pkg::*;
#(
  parameter int NODE_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 msiMode,
  input  logic [15:0]          ownId,
  input  logic [7:0]           busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic                 localEvent,
  input  logic                 tblWe,
  input  logic [NODE_BITS-1:0] tblPeer,
  input  logic [7:0]           tblCount,
  input  logic                 cntWe,
  input  logic [NODE_BITS:0]   cntVal,
  output logic                 irqOut,
  output logic                 notifyValid,
  output logic [15:0]          notifyPeer,
  output logic [7:0]           notifyVector
);
  strobe_t strobes;

  dbl_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  dbl_dp #(.NODE_BITS(NODE_BITS)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .busWdata     (busWdata),
    .msiMode      (msiMode),
    .ownId        (ownId),
    .localEvent   (localEvent),
    .tblWe        (tblWe),
    .tblPeer      (tblPeer),
    .tblCount     (tblCount),
    .cntWe        (cntWe),
    .cntVal       (cntVal),
    .busRdata     (busRdata),
    .irqOut       (irqOut),
    .notifyValid  (notifyValid),
    .notifyPeer   (notifyPeer),
    .notifyVector (notifyVector)
  );
endmodule

// File: tb/tb_doorbell_regs.sv
`timescale 1ns/1ps
module tb_doorbell_regs;
  localparam int NB = 4;
  localparam int NPEER = 1 << NB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msiMode = 1'b0;
  logic [15:0] ownId = 16'h0007;
  logic [7:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic localEvent = 1'b0;
  logic tblWe = 1'b0;
  logic [NB-1:0] tblPeer = '0;
  logic [7:0] tblCount = '0;
  logic cntWe = 1'b0;
  logic [NB:0] cntVal = '0;
  logic irqOut, notifyValid;
  logic [15:0] notifyPeer;
  logic [7:0] notifyVector;

  doorbell_regs #(.NODE_BITS(NB)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [31:0] mMask = '0, mStatus = '0, mRd = '0;
  int mPeerCnt = 0;
  int mTbl [NPEER];
  bit mNv = 0;
  int mNp = 0, mNvec = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    busWrEn = 0; busRdEn = 0; busAddr = '0; busWdata = '0;
    localEvent = 0; tblWe = 0; cntWe = 0;
  endtask

  task automatic modelStep();
    logic [31:0] ns;
    int p, v;
    mNv = 0;
    ns = mStatus;
    if (busRdEn) begin
      case (busAddr)
        8'h00: mRd = mMask;
        8'h04: mRd = mStatus;
        8'h08: mRd = {16'h0, ownId};
        default: mRd = '0;
      endcase
      if (busAddr == 8'h04) ns = '0;
    end else mRd = '0;
    if (busWrEn) begin
      case (busAddr & 8'hFC)
        8'h00: mMask = busWdata;
        8'h04: ns = busWdata;
        8'h0C: begin
          p = int'(busWdata[31:16]);
          v = int'(busWdata[7:0]);
          if (p < mPeerCnt && v < mTbl[p]) begin
            mNv = 1; mNp = p; mNvec = v;
          end
        end
        default: ;
      endcase
    end
    if (localEvent) ns = 32'd1;
    mStatus = ns;
    if (tblWe) mTbl[tblPeer] = int'(tblCount);
    if (cntWe) mPeerCnt = (int'(cntVal) > NPEER) ? NPEER : int'(cntVal);
  endtask

  task automatic tick();
    bit expIrq;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    expIrq = !msiMode && ((mStatus & mMask) != 0);
    chk(irqOut == expIrq, msiMode ? "R5" : "R4", 32'(irqOut), 32'(expIrq));
    chk(busRdata == mRd, curReq, busRdata, mRd);
    chk(notifyValid == mNv, curReq, 32'(notifyValid), 32'(mNv));
    if (mNv) begin
      chk(notifyPeer == 16'(mNp), curReq, 32'(notifyPeer), 32'(mNp));
      chk(notifyVector == 8'(mNvec), curReq, 32'(notifyVector), 32'(mNvec));
    end
    idle();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrEn = 1; tick();
  endtask

  task automatic rd(input logic [7:0] a);
    busAddr = a; busRdEn = 1; tick();
  endtask

  function automatic logic [31:0] bell(input int p, input int v);
    return {16'(p), 8'h5A, 8'(v)};
  endfunction

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPEER; i++) mTbl[i] = 0;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    curReq = "R1";
    chk(irqOut == 0, "R1", 32'(irqOut), 0);
    chk(notifyValid == 0, "R1", 32'(notifyValid), 0);
    rd(8'h00); rd(8'h04);

    // R13: sideband loads
    curReq = "R13";
    cntWe = 1; cntVal = 5'd3; tick();
    tblWe = 1; tblPeer = 0; tblCount = 8'd2; tick();
    tblWe = 1; tblPeer = 2; tblCount = 8'd5; tick();

    // R2: mask
    curReq = "R2";
    wr(8'h00, 32'hA5A5_0003); rd(8'h00); tick();

    // R4 / R3: status, irq, read clears
    curReq = "R3";
    wr(8'h04, 32'h0000_0002);
    wr(8'h04, 32'h0000_0004);
    wr(8'h04, 32'h0000_0006);
    rd(8'h04); rd(8'h04);

    // R6
    curReq = "R6";
    rd(8'h08);

    // R7: accepted doorbells, back to back
    curReq = "R7";
    wr(8'h0C, bell(2, 4));
    wr(8'h0C, bell(0, 1));
    wr(8'h0C, bell(2, 0));
    tick();

    // R8: peer out of range
    curReq = "R8";
    wr(8'h0C, bell(3, 0));
    wr(8'h0C, bell(16'hFFFF, 0));

    // R9: vector out of range
    curReq = "R9";
    wr(8'h0C, bell(1, 0));
    wr(8'h0C, bell(2, 5));
    wr(8'h0C, bell(0, 2));

    // R10: write alias by low address bits
    curReq = "R10";
    wr(8'h0F, bell(2, 3));
    wr(8'h02, 32'h0000_00F1); rd(8'h00);

    // R11: unmapped reads and writes
    curReq = "R11";
    rd(8'h0C); rd(8'h05); rd(8'h10); rd(8'hFC);
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h00); rd(8'h04);

    // R12: local events and same-cycle ordering
    curReq = "R12";
    localEvent = 1; tick();
    localEvent = 1; busAddr = 8'h04; busRdEn = 1; tick();
    rd(8'h04);
    localEvent = 1; busAddr = 8'h04; busWdata = 32'h80; busWrEn = 1; tick();
    rd(8'h04);
    localEvent = 1; tick();

    // R5: message-signalled mode holds the pin low
    curReq = "R5";
    msiMode = 1; tick(); tick();
    wr(8'h04, 32'hFFFF_FFFF); tick();
    msiMode = 0; tick();
    rd(8'h04);

    // R13: clamp and update ordering
    curReq = "R13";
    cntWe = 1; cntVal = 5'd31; tick();
    tblWe = 1; tblPeer = 4'd15; tblCount = 8'd1; tick();
    wr(8'h0C, bell(15, 0));
    wr(8'h0C, bell(16, 0));
    tblWe = 1; tblPeer = 4'd15; tblCount = 8'd0;
    busAddr = 8'h0C; busWdata = bell(15, 0); busWrEn = 1; tick();
    wr(8'h0C, bell(15, 0));
    cntWe = 1; cntVal = 5'd0; tick();
    wr(8'h0C, bell(0, 0));

    // R1: reset clears again
    curReq = "R1";
    wr(8'h00, 32'h1); wr(8'h04, 32'h1);
    rstN = 0; @(negedge clk); @(negedge clk);
    rstN = 1;
    mMask = 0; mStatus = 0; mRd = 0; mPeerCnt = 0;
    for (int i = 0; i < NPEER; i++) mTbl[i] = 0;
    chk(irqOut == 0, "R1", 32'(irqOut), 0);
    rd(8'h00); rd(8'h04);
    wr(8'h0C, bell(0, 0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule